// File: doc/BRIEF.md
# Data Converter Configuration Serial Slave

This block is the configuration port of a high-speed data converter. A host reaches it over three wires: a serial clock, an active-low select and one data line whose pad is shared between the two directions. The block gives the pad a separate input, output and output-enable. Each access is a frame. The frame opens with a 16-bit instruction that holds a read/write flag, a length code and a byte address. Whole data bytes follow and move into or out of a small byte-addressed register file. The address steps up by one after each byte.

The host's serial lines are taken into the block's own clock domain through synchronizer stages. Bits are sampled on the rising edges of the serial clock. On a read, the block launches each outgoing bit on the falling edge before the host samples it. Bit order is MSB-first after reset, and a configuration bit switches it to LSB-first. The register file drives the converter's output-format select, test-pattern select and power-down controls, and it also reports a fixed identity byte. A hardware reset loads defaults into these registers.

Top module: `adc_cfg_spi`

## Requirements
- R1: While and after `rstN` is low, `outFormat` is 3'b001, `testPattern` is 0, `powerDown` is 0, `sdioOe` is 0 and transfers are MSB-first.
- R2: The first 16 bits sampled after select falls form the instruction: bit 15 is 1 for read and 0 for write, bits 14:13 are the length code and bits 12:0 are the start address. `sdioOe` stays 0 throughout the instruction.
- R3: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 bytes. Serial clocks beyond that count change no register, and on a read the data line is released after the last byte.
- R4: Length code 11 keeps transferring bytes until select rises, and the address increases by one after every byte in all modes.
- R5: A written byte updates its register: address 0x08 bits 1:0 drive `powerDown`, 0x0D bits 3:0 drive `testPattern`, 0x14 bits 2:0 drive `outFormat`, and 0x00 bit 6 selects LSB-first.
- R6: During the data phase of a read, `sdioOe` is 1. Each bit appears on `sdioOut` after the falling serial edge that follows the previous rising edge, so it is valid at the next rising edge. `sdioOe` is 0 whenever select is high.
- R7: Unused bit positions at a used address read as 0. Address 0x01 always reads the identity byte (default 8'h4C) and ignores writes. A write to an address with no register changes nothing, and a read from it returns 0.
- R8: With 0x00 bit 6 set, every following byte is sent LSB-first in both directions, and the 16-bit instruction is sent as a whole word starting with its bit 0. The change takes effect from the byte after the one that wrote it.
- R9: Raising select in the middle of a byte ends the frame. The partial byte is never written, and the next frame starts again with a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial lines are oversampled with it |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| spiSclk | input | 1 | Serial clock from the host |
| spiCsN | input | 1 | Active-low frame select |
| sdioIn | input | 1 | Data line as seen from the pad input |
| sdioOut | output | 1 | Read data towards the pad |
| sdioOe | output | 1 | Pad output enable for read data |
| powerDown | output | 2 | Power-down control field |
| testPattern | output | 4 | Test-pattern select field |
| outFormat | output | 3 | Output data format select field |

## Verification
The hardest situations to reach are those where the frame state and the stored state interact. One is a write that flips the bit order partway through a streamed frame, so that the very next byte must already be taken in the other order. Another is select rising a few bits into a data byte. The stimulus reaches these by passing the frame task a bit position at which to abort, and by letting the bench model update its own bit-order flag at each byte boundary exactly as a host would. Reads that run past their length code show whether the data line is released on time.

// File: rtl/adc_cfg_spi_pkg.sv
package adc_cfg_spi_pkg;

  localparam int ADDR_W  = 13;
  localparam int INSTR_W = 16;
  localparam int BYTE_W  = 8;

  // bit of the chip configuration byte that selects LSB-first order
  localparam int LSB_BIT = 6;

  localparam logic [ADDR_W-1:0] ADR_CHIPCFG = 13'h000;
  localparam logic [ADDR_W-1:0] ADR_IDENT   = 13'h001;
  localparam logic [ADDR_W-1:0] ADR_POWER   = 13'h008;
  localparam logic [ADDR_W-1:0] ADR_TESTPAT = 13'h00D;
  localparam logic [ADDR_W-1:0] ADR_FORMAT  = 13'h014;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INSTR,
    PH_DATA,
    PH_DONE
  } phaseT;

  typedef struct packed {
    logic              wrStb;
    logic [ADDR_W-1:0] wrAddr;
    logic [BYTE_W-1:0] wrData;
  } regReqT;

endpackage

// File: rtl/adc_cfg_spi_ctrl.sv
module adc_cfg_spi_ctrl
  import adc_cfg_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCsN,
  input  logic              sdioIn,
  input  logic              lsbFirst,
  input  logic [BYTE_W-1:0] rdData,
  output regReqT            req,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sdioOut,
  output logic              sdioOe
);

  localparam logic [3:0] INSTR_LAST = 4'(INSTR_W - 1);
  localparam logic [3:0] BYTE_LAST  = 4'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] csPipe, sclkPipe, sdiPipe;
  logic csS, sclkS, sdiS, sclkLast, csLast;
  logic sclkRise, sclkFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      sclkLast <= 1'b0;
      csLast   <= 1'b1;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-2:0], spiCsN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], spiSclk};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-2:0], sdioIn};
      sclkLast <= sclkS;
      csLast   <= csS;
    end
  end

  assign csS   = csPipe[SYNC_STAGES-1];
  assign sclkS = sclkPipe[SYNC_STAGES-1];
  assign sdiS  = sdiPipe[SYNC_STAGES-1];

  assign sclkRise = ~csS & sclkS & ~sclkLast;
  assign sclkFall = ~csS & ~sclkS & sclkLast;

  phaseT             phase;
  logic [3:0]        bitCnt;
  logic [1:0]        byteCnt;
  logic [1:0]        lenCode;
  logic              isRead;
  logic              loadTx;
  logic [INSTR_W-1:0] instrSh, instrNext;
  logic [BYTE_W-1:0]  dataSh, dataNext, txByte;
  logic [ADDR_W-1:0]  curAddr;
  logic              lastByte;

  assign instrNext = lsbFirst ? {sdiS, instrSh[INSTR_W-1:1]} : {instrSh[INSTR_W-2:0], sdiS};
  assign dataNext  = lsbFirst ? {sdiS, dataSh[BYTE_W-1:1]}   : {dataSh[BYTE_W-2:0], sdiS};
  assign lastByte  = (lenCode != 2'b11) && (byteCnt == lenCode);
  assign rdAddr    = curAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      lenCode <= '0;
      isRead  <= 1'b0;
      loadTx  <= 1'b0;
      instrSh <= '0;
      dataSh  <= '0;
      txByte  <= '0;
      curAddr <= '0;
      req     <= '0;
      sdioOut <= 1'b0;
      sdioOe  <= 1'b0;
    end else begin
      req.wrStb <= 1'b0;
      loadTx    <= 1'b0;
      if (loadTx) txByte <= rdData;
      if (csS) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        sdioOe <= 1'b0;
      end else if (sclkRise) begin
        unique case (phase)
          PH_IDLE, PH_INSTR: begin
            instrSh <= instrNext;
            if (bitCnt == INSTR_LAST) begin
              phase   <= PH_DATA;
              bitCnt  <= '0;
              byteCnt <= '0;
              isRead  <= instrNext[INSTR_W-1];
              lenCode <= instrNext[INSTR_W-2:INSTR_W-3];
              curAddr <= instrNext[ADDR_W-1:0];
              loadTx  <= instrNext[INSTR_W-1];
            end else begin
              phase  <= PH_INSTR;
              bitCnt <= bitCnt + 4'd1;
            end
          end
          PH_DATA: begin
            dataSh <= dataNext;
            if (bitCnt == BYTE_LAST) begin
              bitCnt  <= '0;
              curAddr <= curAddr + 1'b1;
              if (!isRead) begin
                req.wrStb  <= 1'b1;
                req.wrAddr <= curAddr;
                req.wrData <= dataNext;
              end
              if (lastByte) begin
                phase  <= PH_DONE;
                sdioOe <= 1'b0;
              end else begin
                byteCnt <= byteCnt + 2'd1;
                loadTx  <= isRead;
              end
            end else begin
              bitCnt <= bitCnt + 4'd1;
            end
          end
          default: ;
        endcase
      end else if (sclkFall && phase == PH_DATA && isRead) begin
        sdioOe  <= 1'b1;
        sdioOut <= lsbFirst ? txByte[bitCnt[2:0]] : txByte[3'd7 - bitCnt[2:0]];
      end
    end
  end

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !sdioOe);

  // R2
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdioOe |-> (isRead && phase == PH_DATA));

  // R9
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csS && csLast) |-> !req.wrStb);

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |=> !req.wrStb);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitCnt <= BYTE_LAST));

endmodule

// File: rtl/adc_cfg_spi_regs.sv
module adc_cfg_spi_regs
  import adc_cfg_spi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID     = 8'h4C,
  parameter int                PWR_W       = 2,
  parameter int                PAT_W       = 4,
  parameter int                FMT_W       = 3,
  parameter logic [FMT_W-1:0]  FMT_DEFAULT = 3'b001
) (
  input  logic              clk,
  input  logic              rstN,
  input  regReqT            req,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              lsbFirst,
  output logic [PWR_W-1:0]  powerDown,
  output logic [PAT_W-1:0]  testPattern,
  output logic [FMT_W-1:0]  outFormat
);

  logic isMapped;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lsbFirst    <= 1'b0;
      powerDown   <= '0;
      testPattern <= '0;
      outFormat   <= FMT_DEFAULT;
    end else if (req.wrStb) begin
      case (req.wrAddr)
        ADR_CHIPCFG: lsbFirst    <= req.wrData[LSB_BIT];
        ADR_POWER:   powerDown   <= req.wrData[PWR_W-1:0];
        ADR_TESTPAT: testPattern <= req.wrData[PAT_W-1:0];
        ADR_FORMAT:  outFormat   <= req.wrData[FMT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_CHIPCFG: rdData[LSB_BIT]     = lsbFirst;
      ADR_IDENT:   rdData              = CHIP_ID;
      ADR_POWER:   rdData[PWR_W-1:0]   = powerDown;
      ADR_TESTPAT: rdData[PAT_W-1:0]   = testPattern;
      ADR_FORMAT:  rdData[FMT_W-1:0]   = outFormat;
      default: ;
    endcase
  end

  assign isMapped = (req.wrAddr == ADR_CHIPCFG) || (req.wrAddr == ADR_POWER) ||
                    (req.wrAddr == ADR_TESTPAT) || (req.wrAddr == ADR_FORMAT);

  // R7
  open_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req.wrStb && !isMapped) |=> $stable({lsbFirst, powerDown, testPattern, outFormat}));

  // R5
  fmt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req.wrStb && req.wrAddr == ADR_FORMAT) |=> (outFormat == $past(req.wrData[FMT_W-1:0])));

  // R5
  pat_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (req.wrStb && req.wrAddr == ADR_TESTPAT) |=> (testPattern == $past(req.wrData[PAT_W-1:0])));

endmodule

// File: rtl/adc_cfg_spi.sv
module adc_cfg_spi
  import adc_cfg_spi_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CHIP_ID     = 8'h4C,
  parameter int                PWR_W       = 2,
  parameter int                PAT_W       = 4,
  parameter int                FMT_W       = 3,
  parameter logic [FMT_W-1:0]  FMT_DEFAULT = 3'b001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiSclk,
  input  logic             spiCsN,
  input  logic             sdioIn,
  output logic             sdioOut,
  output logic             sdioOe,
  output logic [PWR_W-1:0] powerDown,
  output logic [PAT_W-1:0] testPattern,
  output logic [FMT_W-1:0] outFormat
);

  regReqT            req;
  logic [ADDR_W-1:0] rdAddr;
  logic [BYTE_W-1:0] rdData;
  logic              lsbFirst;

  adc_cfg_spi_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .spiSclk (spiSclk),
    .spiCsN  (spiCsN),
    .sdioIn  (sdioIn),
    .lsbFirst(lsbFirst),
    .rdData  (rdData),
    .req     (req),
    .rdAddr  (rdAddr),
    .sdioOut (sdioOut),
    .sdioOe  (sdioOe)
  );

  adc_cfg_spi_regs #(
    .CHIP_ID    (CHIP_ID),
    .PWR_W      (PWR_W),
    .PAT_W      (PAT_W),
    .FMT_W      (FMT_W),
    .FMT_DEFAULT(FMT_DEFAULT)
  ) i_regs (
    .clk        (clk),
    .rstN       (rstN),
    .req        (req),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .lsbFirst   (lsbFirst),
    .powerDown  (powerDown),
    .testPattern(testPattern),
    .outFormat  (outFormat)
  );

endmodule

// File: tb/test_adc_cfg_spi.sv
module test_adc_cfg_spi;

  localparam logic [7:0] IDENT = 8'h4C;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN, spiSclk, spiCsN, sdioIn;
  logic sdioOut, sdioOe;
  logic [1:0] powerDown;
  logic [3:0] testPattern;
  logic [2:0] outFormat;

  int compared = 0;
  int mismatched = 0;
  int idleCnt = 0;
  bit finished = 1'b0;

  // behavioural register model
  bit       mLsb;
  bit [1:0] mPwr;
  bit [3:0] mTest;
  bit [2:0] mFmt;

  always #2 clk = ~clk;

  adc_cfg_spi i_adc_cfg_spi (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .powerDown(powerDown),
    .testPattern(testPattern), .outFormat(outFormat)
  );

  task automatic mdlReset();
    mLsb = 1'b0; mPwr = '0; mTest = '0; mFmt = 3'b001;
  endtask

  function automatic logic [7:0] mdlRead(input logic [12:0] a);
    case (a)
      13'h000: return {1'b0, mLsb, 6'b0};
      13'h001: return IDENT;
      13'h008: return {6'b0, mPwr};
      13'h00D: return {4'b0, mTest};
      13'h014: return {5'b0, mFmt};
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdlWrite(input logic [12:0] a, input logic [7:0] d);
    case (a)
      13'h000: mLsb  = d[6];
      13'h008: mPwr  = d[1:0];
      13'h00D: mTest = d[3:0];
      13'h014: mFmt  = d[2:0];
      default: ;
    endcase
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compared on every clock while the port is idle and settled
  always @(negedge clk) begin
    if (!rstN || !spiCsN) idleCnt = 0;
    else idleCnt++;
    if (rstN && spiCsN && idleCnt >= 6 && !finished) begin
      checkEq("R5 outFormat", {29'b0, outFormat}, {29'b0, mFmt});
      checkEq("R5 testPattern", {28'b0, testPattern}, {28'b0, mTest});
      checkEq("R5 powerDown", {30'b0, powerDown}, {30'b0, mPwr});
      checkEq("R6 oe idle", {31'b0, sdioOe}, 32'd0);
    end
  end

  task automatic pulseBit(input logic b, input bit chkData, input bit expOe,
                          input logic expBit, input string tag);
    sdioIn = b;
    repeat (5) @(negedge clk);
    checkEq({tag, " oe"}, {31'b0, sdioOe}, {31'b0, expOe});
    if (chkData) checkEq({tag, " data"}, {31'b0, sdioOut}, {31'b0, expBit});
    @(negedge clk);
    spiSclk = 1'b1;
    repeat (6) @(negedge clk);
    spiSclk = 1'b0;
  endtask

  task automatic endFrame();
    repeat (4) @(negedge clk);
    spiCsN = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  task automatic runFrame(input bit rd, input bit [1:0] len, input bit [12:0] addr,
                          input logic [7:0] wq[$], input int nBytes, input int abortAt,
                          input string tag);
    logic [15:0] iw;
    logic [7:0]  curByte, expByte;
    logic [12:0] a;
    bit ordLsb, active;
    int total;
    iw = {rd, len, addr};
    @(negedge clk);
    spiSclk = 1'b0;
    spiCsN  = 1'b0;
    repeat (6) @(negedge clk);
    total  = 0;
    ordLsb = mLsb;
    for (int i = 0; i < 16; i++) begin
      if (total == abortAt) begin endFrame(); return; end
      pulseBit(ordLsb ? iw[i] : iw[15-i], 1'b0, 1'b0, 1'b0, {tag, " R2 instr"});
      total++;
    end
    for (int k = 0; k < nBytes; k++) begin
      active  = (len == 2'b11) || (k <= int'(len));
      ordLsb  = mLsb;
      a       = 13'(addr + 13'(k));
      expByte = mdlRead(a);
      curByte = rd ? 8'h00 : wq[k];
      for (int j = 0; j < 8; j++) begin
        if (total == abortAt) begin endFrame(); return; end
        pulseBit(ordLsb ? curByte[j] : curByte[7-j], rd && active, rd && active,
                 ordLsb ? expByte[j] : expByte[7-j], tag);
        total++;
      end
      if (!rd && active) mdlWrite(a, curByte);
    end
    endFrame();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    mdlReset();
    repeat (5) @(negedge clk);
    checkEq("R1 reset outFormat", {29'b0, outFormat}, 32'd1);
    checkEq("R1 reset testPattern", {28'b0, testPattern}, 32'd0);
    checkEq("R1 reset powerDown", {30'b0, powerDown}, 32'd0);
    checkEq("R1 reset oe", {31'b0, sdioOe}, 32'd0);
    rstN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] none[$];
    none = {};
    spiSclk = 1'b0; spiCsN = 1'b1; sdioIn = 1'b0; rstN = 1'b1;
    mdlReset();
    doReset();

    // R1 R7: reset contents read back, identity byte
    runFrame(1'b1, 2'b01, 13'h000, none, 2, -1, "R1 R7 read cfg+ident");
    // R5 R7: write test pattern with open high bits, read back
    q = {8'h5A};
    runFrame(1'b0, 2'b00, 13'h00D, q, 1, -1, "R5 write pattern");
    runFrame(1'b1, 2'b00, 13'h00D, none, 1, -1, "R7 read pattern");
    // R7: identity ignores writes
    q = {8'hFF};
    runFrame(1'b0, 2'b00, 13'h001, q, 1, -1, "R7 write ident");
    runFrame(1'b1, 2'b00, 13'h001, none, 1, -1, "R7 read ident");
    // R3 R4: two-byte write through an open address into the format register
    q = {8'hEE, 8'h06};
    runFrame(1'b0, 2'b01, 13'h013, q, 2, -1, "R3 R4 two byte write");
    // R3: length 00 with extra clocks, second byte must not land
    q = {8'h02, 8'h03};
    runFrame(1'b0, 2'b00, 13'h008, q, 2, -1, "R3 extra clocks write");
    q = {8'h01, 8'hFF};
    runFrame(1'b0, 2'b00, 13'h013, q, 2, -1, "R3 extra clocks open");
    // R3 R6: read with length 10 and an extra byte; line released after third
    runFrame(1'b1, 2'b10, 13'h00C, none, 4, -1, "R3 R6 three byte read");
    // R4: streaming write then streaming read
    q = {8'h77, 8'h0C, 8'h55, 8'h99};
    runFrame(1'b0, 2'b11, 13'h00C, q, 4, -1, "R4 stream write");
    runFrame(1'b1, 2'b11, 13'h006, none, 4, -1, "R4 stream read");
    // R7: fully open address ignores writes and reads zero
    q = {8'hFF};
    runFrame(1'b0, 2'b00, 13'h030, q, 1, -1, "R7 open write");
    runFrame(1'b1, 2'b00, 13'h030, none, 1, -1, "R7 open read");
    // R9: abort inside data byte and inside instruction
    q = {8'h03};
    runFrame(1'b0, 2'b00, 13'h008, q, 1, 21, "R9 abort data");
    runFrame(1'b0, 2'b00, 13'h014, q, 1, 9, "R9 abort instr");
    runFrame(1'b1, 2'b00, 13'h008, none, 1, -1, "R9 read after abort");
    // R8: switch to LSB-first, then frames in that order
    q = {8'h40};
    runFrame(1'b0, 2'b00, 13'h000, q, 1, -1, "R8 set lsb");
    q = {8'h0B};
    runFrame(1'b0, 2'b00, 13'h00D, q, 1, -1, "R8 lsb write");
    runFrame(1'b1, 2'b10, 13'h000, none, 3, -1, "R8 lsb read");
    // R8: streamed frame that switches order back at its first byte
    q = {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02};
    runFrame(1'b0, 2'b11, 13'h000, q, 8, -1, "R8 order change mid frame");
    runFrame(1'b1, 2'b01, 13'h007, none, 2, -1, "R8 msb read back");
    // R1: hardware reset restores defaults
    q = {8'h05};
    runFrame(1'b0, 2'b00, 13'h014, q, 1, -1, "R5 format write");
    doReset();
    runFrame(1'b1, 2'b11, 13'h012, none, 4, -1, "R1 read after reset");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule